// File: doc/BRIEF.md
# Dual Out-of-Frequency Monitor

This block watches four clock inputs and reports, for each one, whether its frequency has drifted from a chosen 0 ppm reference. The reference is the crystal clock by default, but any of the four monitored inputs can stand in for it. All clocks are sampled in the system clock domain. The block counts rising edges of each monitored clock inside gate windows that are measured in reference edges. Each input is judged by two detectors at once. A precision detector uses a long gate and set/clear thresholds in 1/16 ppm units, so that its flag has hysteresis. A fast detector uses a short gate and its own, wider thresholds, so that it reacts sooner and with coarser resolution.

Each detector has its own enable. The two enabled results are ORed into a live out-of-frequency flag per input. A sticky copy of each flag is held until software writes a zero to that bit. The maskable sticky bits are ORed into one interrupt line. Deviation is computed as the distance between the counted edges and an expected count, scaled to 1/16 ppm. The expected count and the gate length are parameters of each detector.

Top module: `oof_monitor`

## Requirements
- R1: While reset is held and in the first cycle after reset, `oof_live`, `oof_sticky` and `irq` are all zero.
- R2: Every clock is resynchronized through two flops, and its rising edge is counted in the cycle after that. A window closes on the GATE-th reference edge, and a monitored edge in that same cycle belongs to the closing window. The detector result updates at that edge and is visible in the following cycle.
- R3: Precision deviation is |count − PREC_EXP| × (16,000,000 / PREC_EXP) in 1/16 ppm. A clear detector sets when the deviation is strictly greater than `prec_set_thr`. A set detector clears only when the deviation is at most `prec_clr_thr`.
- R4: The fast detector follows the same rule with FAST_GATE, FAST_EXP, `fast_set_thr` and `fast_clr_thr`.
- R5: `oof_live[i]` is the OR of the precision result gated by `prec_en[i]` and the fast result gated by `fast_en[i]`. A disabled detector contributes 0 at once, and its state is cleared at the next edge.
- R6: `ref_sel` value 0 selects the crystal, and values 1 to 4 select IN0 to IN3. Any other value selects the crystal.
- R7: `oof_sticky[i]` becomes 1 in the cycle after any cycle with `oof_live[i]` high, and then holds.
- R8: A cycle with `sticky_wr` high clears every sticky bit whose `sticky_wdata` bit is 0. Bits written with 1 are unchanged. A clear is ignored for a bit whose live flag is high in that same cycle.
- R9: `irq` is high while any sticky bit with `irq_mask` bit 0 is set. A mask bit of 1 removes that input from the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | Crystal reference clock |
| in_clk | input | NIN | Monitored clocks, bit i is IN i |
| ref_sel | input | 3 | Reference select (R6) |
| prec_en | input | NIN | Precision detector enables |
| fast_en | input | NIN | Fast detector enables |
| prec_set_thr | input | TW | Precision set threshold, 1/16 ppm |
| prec_clr_thr | input | TW | Precision clear threshold, 1/16 ppm |
| fast_set_thr | input | TW | Fast set threshold, 1/16 ppm |
| fast_clr_thr | input | TW | Fast clear threshold, 1/16 ppm |
| irq_mask | input | NIN | Interrupt mask, 1 masks |
| sticky_wr | input | 1 | Sticky write strobe |
| sticky_wdata | input | NIN | Sticky write data, 0 clears |
| oof_live | output | NIN | Live out-of-frequency flags |
| oof_sticky | output | NIN | Sticky out-of-frequency flags |
| irq | output | 1 | Interrupt |

## Verification
A sticky clear write and a live out-of-frequency condition can arrive in the same cycle. The bench provokes this by holding IN3 off frequency with only its fast detector enabled and then writing zero to its sticky bit. The set must win, and the bit stays at 1. A window close can also coincide with a monitored edge, and this happens often with free-running clocks of unrelated periods. A behavioural model with its own edge counts is compared with the outputs on every clock, which judges that case and the hysteresis under changing periods and references.

// File: rtl/oof_monitor.sv
module oof_monitor #(
  parameter int NIN       = 4,
  parameter int PREC_GATE = 32,
  parameter int PREC_EXP  = 32,
  parameter int FAST_GATE = 8,
  parameter int FAST_EXP  = 8,
  parameter int TW        = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xtal_clk,
  input  logic [NIN-1:0] in_clk,
  input  logic [2:0]     ref_sel,
  input  logic [NIN-1:0] prec_en,
  input  logic [NIN-1:0] fast_en,
  input  logic [TW-1:0]  prec_set_thr,
  input  logic [TW-1:0]  prec_clr_thr,
  input  logic [TW-1:0]  fast_set_thr,
  input  logic [TW-1:0]  fast_clr_thr,
  input  logic [NIN-1:0] irq_mask,
  input  logic           sticky_wr,
  input  logic [NIN-1:0] sticky_wdata,
  output logic [NIN-1:0] oof_live,
  output logic [NIN-1:0] oof_sticky,
  output logic           irq
);
  localparam int PCW  = $clog2(2 * PREC_EXP + 1);
  localparam int FCW  = $clog2(2 * FAST_EXP + 1);
  localparam int PGW  = $clog2(PREC_GATE);
  localparam int FGW  = $clog2(FAST_GATE);
  localparam int PLSB = 16000000 / PREC_EXP;
  localparam int FLSB = 16000000 / FAST_EXP;
  localparam int DW   = 26 + TW + PCW + FCW;

  logic [NIN:0] raw, s1, s2, s3, edg;
  logic         ref_edge, pend, fend;
  logic [PGW-1:0] pg;
  logic [FGW-1:0] fg;
  logic [NIN-1:0] pdet, fdet;

  assign raw = {in_clk, xtal_clk};
  assign edg = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2;
    end

  always_comb begin
    ref_edge = edg[0];
    for (int k = 1; k <= NIN; k++)
      if (int'(ref_sel) == k) ref_edge = edg[k];
  end

  assign pend = ref_edge && (pg == PGW'(PREC_GATE - 1));
  assign fend = ref_edge && (fg == FGW'(FAST_GATE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg <= '0; fg <= '0;
    end else if (ref_edge) begin
      pg <= pend ? '0 : pg + 1'b1;
      fg <= fend ? '0 : fg + 1'b1;
    end

  for (genvar i = 0; i < NIN; i++) begin : g_in
    logic [PCW-1:0] pc, ptot, pdif;
    logic [FCW-1:0] fc, ftot, fdif;
    logic [DW-1:0]  pdev, fdev;
    logic           pd, fd;

    assign ptot = (&pc) ? pc : pc + PCW'(edg[i+1]);
    assign ftot = (&fc) ? fc : fc + FCW'(edg[i+1]);
    assign pdif = (ptot >= PCW'(PREC_EXP)) ? ptot - PCW'(PREC_EXP) : PCW'(PREC_EXP) - ptot;
    assign fdif = (ftot >= FCW'(FAST_EXP)) ? ftot - FCW'(FAST_EXP) : FCW'(FAST_EXP) - ftot;
    assign pdev = DW'(pdif) * DW'(PLSB);
    assign fdev = DW'(fdif) * DW'(FLSB);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pc <= '0; fc <= '0; pd <= 1'b0; fd <= 1'b0;
      end else begin
        pc <= pend ? '0 : ptot;
        fc <= fend ? '0 : ftot;
        if (!prec_en[i]) pd <= 1'b0;
        else if (pend)   pd <= pd ? (pdev > DW'(prec_clr_thr)) : (pdev > DW'(prec_set_thr));
        if (!fast_en[i]) fd <= 1'b0;
        else if (fend)   fd <= fd ? (fdev > DW'(fast_clr_thr)) : (fdev > DW'(fast_set_thr));
      end

    assign pdet[i] = pd;
    assign fdet[i] = fd;
  end

  assign oof_live = (prec_en & pdet) | (fast_en & fdet);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oof_sticky <= '0;
    else        oof_sticky <= oof_live | (oof_sticky & ~(sticky_wr ? ~sticky_wdata : '0));

  assign irq = |(oof_sticky & ~irq_mask);
endmodule

// File: rtl/oof_monitor_chk.sv
module oof_monitor_chk #(
  parameter int NIN = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NIN-1:0] prec_en,
  input logic [NIN-1:0] fast_en,
  input logic [NIN-1:0] irq_mask,
  input logic           sticky_wr,
  input logic [NIN-1:0] sticky_wdata,
  input logic [NIN-1:0] oof_live,
  input logic [NIN-1:0] oof_sticky,
  input logic           irq
);
  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_live != '0) |=> ((oof_sticky & $past(oof_live)) == $past(oof_live)));

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_wr |=> ((oof_sticky & $past(oof_sticky)) == $past(oof_sticky)));

  p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_wr && oof_live == '0) |=> ((oof_sticky & ~$past(sticky_wdata)) == '0));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '1) |-> !irq);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((prec_en | fast_en) == '0) |-> (oof_live == '0));

  p_reset_clean_r1: assert property (@(posedge clk)
    !rst_n |=> (oof_sticky == '0));
endmodule

bind oof_monitor oof_monitor_chk #(.NIN(NIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .prec_en(prec_en), .fast_en(fast_en),
  .irq_mask(irq_mask), .sticky_wr(sticky_wr), .sticky_wdata(sticky_wdata),
  .oof_live(oof_live), .oof_sticky(oof_sticky), .irq(irq)
);

// File: tb/oof_monitor_bench.sv
module oof_monitor_bench;
  localparam int CLK_PER = 10;
  localparam int NIN = 4, PG = 32, PE = 32, FG = 8, FE = 8, TW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xtal_clk;
  logic [NIN-1:0] in_clk;
  logic [2:0] ref_sel = 3'd0;
  logic [NIN-1:0] prec_en = '1, fast_en = '1, irq_mask = '0, sticky_wdata = '1;
  logic sticky_wr = 1'b0;
  logic [TW-1:0] prec_set_thr = 24'd2750000, prec_clr_thr = 24'd1600000;
  logic [TW-1:0] fast_set_thr = 24'd5000000, fast_clr_thr = 24'd2500000;
  logic [NIN-1:0] oof_live, oof_sticky;
  logic irq;

  oof_monitor #(.NIN(NIN), .PREC_GATE(PG), .PREC_EXP(PE), .FAST_GATE(FG),
                .FAST_EXP(FE), .TW(TW)) u_oof_monitor (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .in_clk(in_clk),
    .ref_sel(ref_sel), .prec_en(prec_en), .fast_en(fast_en),
    .prec_set_thr(prec_set_thr), .prec_clr_thr(prec_clr_thr),
    .fast_set_thr(fast_set_thr), .fast_clr_thr(fast_clr_thr),
    .irq_mask(irq_mask), .sticky_wr(sticky_wr), .sticky_wdata(sticky_wdata),
    .oof_live(oof_live), .oof_sticky(oof_sticky), .irq(irq));

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus clocks: index 0 crystal, 1..4 IN0..IN3, periods in clk cycles
  int per[5] = '{8, 8, 6, 7, 8};
  int ph[5]  = '{0, 3, 1, 5, 2};
  bit raw[5];
  always @(negedge clk) begin
    for (int k = 0; k < 5; k++) begin
      ph[k] = (ph[k] + 1) % per[k];
      raw[k] = (ph[k] < per[k] / 2);
    end
    xtal_clk = raw[0];
    for (int k = 0; k < NIN; k++) in_clk[k] = raw[k+1];
  end
  initial begin xtal_clk = 1'b0; in_clk = '0; end

  // behavioural reference model
  bit h1[5], h2[5], h3[5];
  int mpg, mfg;
  int mpc[4], mfc[4];
  bit mpd[4], mfd[4], mst[4];

  function automatic bit mlive(int i);
    return (prec_en[i] && mpd[i]) || (fast_en[i] && mfd[i]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin h1[k] = 0; h2[k] = 0; h3[k] = 0; end
      mpg = 0; mfg = 0;
      for (int i = 0; i < 4; i++) begin mpc[i] = 0; mfc[i] = 0; mpd[i] = 0; mfd[i] = 0; mst[i] = 0; end
    end else begin
      bit e[5];
      bit lv[4];
      int r;
      bit refe, pe_, fe_;
      for (int k = 0; k < 5; k++) e[k] = h2[k] && !h3[k];
      r = (ref_sel >= 1 && ref_sel <= 4) ? int'(ref_sel) : 0;
      refe = e[r];
      pe_ = refe && (mpg == PG - 1);
      fe_ = refe && (mfg == FG - 1);
      for (int i = 0; i < 4; i++) lv[i] = mlive(i);
      for (int i = 0; i < 4; i++) begin
        int pt, ft;
        longint pdv, fdv;
        pt = mpc[i] + e[i+1];
        ft = mfc[i] + e[i+1];
        pdv = longint'((pt > PE) ? pt - PE : PE - pt) * (16000000 / PE);
        fdv = longint'((ft > FE) ? ft - FE : FE - ft) * (16000000 / FE);
        mpc[i] = pe_ ? 0 : pt;
        mfc[i] = fe_ ? 0 : ft;
        if (!prec_en[i]) mpd[i] = 0;
        else if (pe_) mpd[i] = mpd[i] ? (pdv > prec_clr_thr) : (pdv > prec_set_thr);
        if (!fast_en[i]) mfd[i] = 0;
        else if (fe_) mfd[i] = mfd[i] ? (fdv > fast_clr_thr) : (fdv > fast_set_thr);
        mst[i] = lv[i] || (mst[i] && !(sticky_wr && !sticky_wdata[i]));
      end
      if (refe) begin
        mpg = pe_ ? 0 : mpg + 1;
        mfg = fe_ ? 0 : mfg + 1;
      end
      for (int k = 0; k < 5; k++) begin h3[k] = h2[k]; h2[k] = h1[k]; h1[k] = raw[k]; end
    end
  end

  // per-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PER/4);
    if (rst_n) begin
      logic [3:0] el, es;
      logic ei;
      for (int i = 0; i < 4; i++) begin el[i] = mlive(i); es[i] = mst[i]; end
      ei = |(es & ~irq_mask);
      chk(oof_live == el, "R2 live per cycle", int'(oof_live), int'(el));
      chk(oof_sticky == es, "R7 sticky per cycle", int'(oof_sticky), int'(es));
      chk(irq == ei, "R9 irq per cycle", int'(irq), int'(ei));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic look;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk(oof_live == 0 && oof_sticky == 0 && irq == 0, "R1 reset state", int'({irq, oof_sticky, oof_live}), 0);
    @(negedge clk) rst_n = 1'b1;
    look;
    chk(oof_live == 0 && oof_sticky == 0 && irq == 0, "R1 after release", int'({irq, oof_sticky, oof_live}), 0);

    run(1500); look;
    chk(oof_live[1] == 1'b1, "R3 IN1 fast by far sets", int'(oof_live[1]), 1);
    chk(oof_live[2] == 1'b0, "R3 IN2 below set threshold", int'(oof_live[2]), 0);
    chk(oof_live[0] == 1'b0, "R3 IN0 on frequency", int'(oof_live[0]), 0);
    chk(oof_sticky[1] == 1'b1 && irq == 1'b1, "R7 sticky and irq after event", int'({irq, oof_sticky[1]}), 3);

    per[2] = 7; run(1500); look;
    chk(oof_live[1] == 1'b1, "R3 hysteresis holds between thresholds", int'(oof_live[1]), 1);

    per[2] = 8; run(1000); look;
    chk(oof_live[1] == 1'b0, "R3 clears inside clear threshold", int'(oof_live[1]), 0);
    chk(oof_sticky[1] == 1'b1, "R7 sticky holds after live clears", int'(oof_sticky[1]), 1);

    @(negedge clk) begin sticky_wr = 1'b1; sticky_wdata = 4'b1111; end
    @(negedge clk) sticky_wr = 1'b0;
    #1;
    chk(oof_sticky[1] == 1'b1, "R8 write of one keeps sticky", int'(oof_sticky[1]), 1);
    @(negedge clk) begin sticky_wr = 1'b1; sticky_wdata = 4'b1101; end
    @(negedge clk) begin sticky_wr = 1'b0; sticky_wdata = 4'b1111; end
    #1;
    chk(oof_sticky == 4'b0000 && irq == 1'b0, "R8 write of zero clears", int'(oof_sticky), 0);

    @(negedge clk) begin prec_en[3] = 1'b0; per[4] = 5; end
    run(400); look;
    chk(oof_live[3] == 1'b1, "R4 fast detector alone flags IN3", int'(oof_live[3]), 1);

    @(negedge clk) fast_en[3] = 1'b0;
    #1;
    chk(oof_live[3] == 1'b0, "R5 disabled detectors contribute zero", int'(oof_live[3]), 0);

    @(negedge clk) fast_en[3] = 1'b1;
    run(400); look;
    chk(oof_live[3] == 1'b1, "R4 fast detector re-enabled", int'(oof_live[3]), 1);
    @(negedge clk) begin sticky_wr = 1'b1; sticky_wdata = 4'b0111; end
    @(negedge clk) begin sticky_wr = 1'b0; sticky_wdata = 4'b1111; end
    #1;
    chk(oof_sticky[3] == 1'b1, "R8 set wins over same-cycle clear", int'(oof_sticky[3]), 1);

    @(negedge clk) irq_mask = 4'b1000;
    #1;
    chk(irq == 1'b0, "R9 masked input raises no irq", int'(irq), 0);
    @(negedge clk) irq_mask = 4'b0000;
    #1;
    chk(irq == 1'b1, "R9 unmasked input raises irq", int'(irq), 1);

    @(negedge clk) begin prec_en[3] = 1'b1; per[4] = 10; ref_sel = 3'd4; end
    run(2000); look;
    chk(oof_live[0] == 1'b1, "R6 IN3 as reference makes IN0 deviate", int'(oof_live[0]), 1);
    chk(oof_live[3] == 1'b0, "R6 reference input matches itself", int'(oof_live[3]), 0);

    @(negedge clk) ref_sel = 3'd6;
    run(2000); look;
    chk(oof_live[0] == 1'b0, "R6 out-of-range select falls back to crystal", int'(oof_live[0]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule